// File: doc/BRIEF.md
# Run-Time Selectable Multi-Policy Bus Arbiter

This block decides which of N bus masters may use a shared slave side. It grants at most one master at a time. A two-bit policy input chooses, at run time, how the next winner is picked. The policies are fixed priority, time-slotted ownership and a rotating turn. All three policies feed one registered grant path.

A grant stays in place until the granted master pulses the transfer-done input. The cycle after that pulse is always idle, and a fresh decision is made in the cycle after it. The policy input is sampled only when no grant is held, so a policy change never disturbs a transfer that is in progress.

The time-slot policy uses a free-running slot counter that runs from reset. The rotating policy uses a turn pointer that moves only when a transfer granted under that policy finishes.

Top module: `multi_policy_arbiter`

## Requirements
- R1: The grant output is one-hot or all zero. A bit is set only for a master whose request was high at the deciding edge. The valid flag is high exactly when the grant is non-zero. Both outputs are registered, so they change on the edge that follows the request.
- R2: Policy codes: 2'b00 is fixed priority, 2'b01 is time-slotted, 2'b10 is rotating turn, and 2'b11 behaves like 2'b00.
- R3: Under fixed priority, the requester with the lowest index wins, so master 0 is highest. There is no aging, and a low master can wait forever.
- R4: A grant is held unchanged while done is low, even if new requests arrive. When done is high while a grant is held, the grant and valid clear on the next edge. No new grant is issued on that same edge.
- R5: The policy input is sampled only in cycles with no grant held. A policy change while a grant is held does not alter the held grant. It also does not alter which policy's state that transfer updates on done.
- R6: The time-slot counter stays on each slot for SLOT_CYC cycles and visits slots 0, 1, …, N-1, then 0 again. It runs in every policy. In an idle cycle, the slot's owner is granted if it requests. Otherwise no grant is issued, even if other masters request.
- R7: Under the rotating policy, the search starts at the turn pointer and goes up through the indices, wrapping at N-1. Masters that are not requesting are skipped. When a granted transfer finishes, the pointer becomes the granted index plus one, modulo N.
- R8: The turn pointer changes only on done of a grant issued under the rotating policy. A done pulse in an idle cycle, or at the end of a transfer granted under another policy, leaves it unchanged.
- R9: Reset is synchronous and active high. It clears the grant and valid, sets the turn pointer to master 0 and sets the time-slot counter to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request line per master |
| mode | input | 2 | Policy select, sampled when idle |
| done | input | 1 | Transfer-done strobe from the granted master |
| gnt | output | N | One-hot grant, registered |
| gnt_valid | output | 1 | High while a grant is held |

## Verification
The bench builds the arbiter with N = 4 and a shortened slot length of SLOT_CYC = 3. With these values, the time-slot counter wraps through all four owners twice in about two dozen cycles. A grant held across a slot boundary is reachable in a few cycles. With four masters, the rotating pointer can be driven through its wrap from master 3 back to master 0. There are also enough masters to show skipped non-requesters and the policy-3 alias.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    POL_FIXED = 2'b00,
    POL_SLOT  = 2'b01,
    POL_RING  = 2'b10
  } arb_pol_e;

  function automatic arb_pol_e decode_pol(input logic [1:0] code);
    case (code)
      2'b01:   decode_pol = POL_SLOT;
      2'b10:   decode_pol = POL_RING;
      default: decode_pol = POL_FIXED;
    endcase
  endfunction

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic [N-1:0]  pick
);

  // first requester at or above base, wrapping past N-1
  always_comb begin
    logic found;
    int   idx;
    pick  = '0;
    found = 1'b0;
    idx   = 0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(base) + i) % N;
      if (!found && req[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/arb_tdma_slot.sv
module arb_tdma_slot #(
  parameter int N        = 4,
  parameter int SLOT_CYC = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] slot
);

  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [CW-1:0] cyc_q;
  logic [IW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (cyc_q == CW'(SLOT_CYC - 1)) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == IW'(N - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign slot = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(slot_q) < N); // R6

  AST_SLOT_DWELL: assert property (@(posedge clk) disable iff (rst)
    (cyc_q != CW'(SLOT_CYC - 1)) |=> $stable(slot_q)); // R6

endmodule

// File: rtl/multi_policy_arbiter.sv
module multi_policy_arbiter
  import arb_pkg::*;
#(
  parameter int N        = 4,
  parameter int SLOT_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [1:0]   mode,
  input  logic         done,
  output logic [N-1:0] gnt,
  output logic         gnt_valid
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  gnt_q;
  logic          valid_q;
  arb_pol_e      pol_q;
  logic [IW-1:0] ptr_q;

  logic [N-1:0]  fix_pick, ring_pick, slot_pick, next_pick;
  logic [IW-1:0] slot_idx, held_idx, ptr_next;
  arb_pol_e      pol_in;

  assign pol_in = decode_pol(mode);

  arb_prio_pick #(.N(N)) u_fixed (
    .req  (req),
    .base ('0),
    .pick (fix_pick)
  );

  arb_prio_pick #(.N(N)) u_ring (
    .req  (req),
    .base (ptr_q),
    .pick (ring_pick)
  );

  arb_tdma_slot #(.N(N), .SLOT_CYC(SLOT_CYC)) u_slot (
    .clk  (clk),
    .rst  (rst),
    .slot (slot_idx)
  );

  assign slot_pick = req & (N'(1) << slot_idx);

  always_comb begin
    case (pol_in)
      POL_SLOT: next_pick = slot_pick;
      POL_RING: next_pick = ring_pick;
      default:  next_pick = fix_pick;
    endcase
  end

  // index of the held grant, for the turn pointer
  always_comb begin
    held_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_q[i]) held_idx = IW'(i);
    end
  end

  assign ptr_next = (held_idx == IW'(N - 1)) ? '0 : held_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      valid_q <= 1'b0;
      pol_q   <= POL_FIXED;
      ptr_q   <= '0;
    end else if (valid_q) begin
      if (done) begin
        gnt_q   <= '0;
        valid_q <= 1'b0;
        if (pol_q == POL_RING) ptr_q <= ptr_next;
      end
    end else begin
      gnt_q   <= next_pick;
      valid_q <= |next_pick;
      pol_q   <= pol_in;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = valid_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R1

  AST_VALID_AGREES: assert property (@(posedge clk) disable iff (rst)
    valid_q == (gnt_q != '0)); // R1

  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    !valid_q |=> ((gnt_q & ~$past(req)) == '0)); // R1

  AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && (mode == 2'b00 || mode == 2'b11) && req != '0)
      |=> gnt_q == $past(req & (~req + 1'b1))); // R3

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !done) |=> $stable(gnt_q)); // R4

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (valid_q && done) |=> (gnt_q == '0 && !valid_q)); // R4

  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> $stable(pol_q)); // R5

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(valid_q && done && pol_q == POL_RING) |=> $stable(ptr_q)); // R8

endmodule

// File: tb/multi_policy_arbiter_bench.sv
module multi_policy_arbiter_bench;

  localparam int N        = 4;
  localparam int SLOT_CYC = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [1:0]   mode = 2'b00;
  logic         done = 1'b0;
  logic [N-1:0] gnt;
  logic         gnt_valid;

  always #5 clk = ~clk;

  multi_policy_arbiter #(.N(N), .SLOT_CYC(SLOT_CYC)) u_multi_policy_arbiter (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .done(done),
    .gnt(gnt), .gnt_valid(gnt_valid)
  );

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t scb[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  int    edges    = 0;
  bit    finished = 0;

  // edges since reset release, used to predict the time-slot owner (R6)
  always @(posedge clk) if (!rst) edges <= edges + 1;

  // monitor: one item per edge, compared half a period later
  always @(negedge clk) begin
    if (scb.size() > 0) begin
      item_t it;
      it = scb.pop_front();
      n_checks++;
      if (gnt !== it.exp || gnt_valid !== (it.exp != '0)) begin
        n_fails++;
        $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b",
                 it.tag, gnt, gnt_valid, it.exp, (it.exp != '0));
      end
    end
  end

  task automatic drive(input logic [N-1:0] r, input logic [1:0] m,
                       input logic d, input logic [N-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    req  = r;
    mode = m;
    done = d;
    @(posedge clk);
    it.exp = e;
    it.tag = tag;
    scb.push_back(it);
  endtask

  // time-slot model state
  logic         ts_busy = 1'b0;
  logic [N-1:0] ts_held = '0;

  task automatic slot_step(input logic [N-1:0] r, input logic d, input string tag);
    item_t        it;
    int           owner;
    logic [N-1:0] e;
    @(negedge clk);
    req   = r;
    mode  = 2'b01;
    done  = d;
    owner = (edges / SLOT_CYC) % N;
    if (ts_busy) begin
      if (d) begin
        e       = '0;
        ts_busy = 1'b0;
      end else begin
        e = ts_held;
      end
    end else if (r[owner]) begin
      e       = N'(1) << owner;
      ts_busy = 1'b1;
    end else begin
      e = '0;
    end
    ts_held = e;
    @(posedge clk);
    it.exp = e;
    it.tag = tag;
    scb.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (gnt !== '0 || gnt_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R9 reset: gnt=%b valid=%b expected gnt=0000 valid=0", gnt, gnt_valid);
    end
    rst = 1'b0;

    // fixed priority
    drive(4'b1110, 2'b00, 0, 4'b0010, "R3 lowest requester wins");
    drive(4'b1111, 2'b00, 0, 4'b0010, "R4 hold despite higher request");
    drive(4'b1111, 2'b00, 1, 4'b0000, "R4 release on done");
    drive(4'b1111, 2'b00, 0, 4'b0001, "R3 master 0 highest");
    drive(4'b1111, 2'b10, 1, 4'b0000, "R5 mode change while held, release");
    drive(4'b1100, 2'b11, 0, 4'b0100, "R2 code 11 acts as fixed");
    drive(4'b1100, 2'b11, 1, 4'b0000, "R4 release");

    // rotating turn; pointer must still be 0 (R9, R8)
    drive(4'b1010, 2'b10, 0, 4'b0010, "R8 pointer untouched by fixed grants");
    drive(4'b1010, 2'b00, 1, 4'b0000, "R5 release under changed mode");
    drive(4'b1010, 2'b10, 0, 4'b1000, "R7 pointer past granted master");
    drive(4'b1010, 2'b10, 1, 4'b0000, "R7 release");
    drive(4'b0000, 2'b10, 1, 4'b0000, "R8 idle done ignored");
    drive(4'b1010, 2'b10, 0, 4'b0010, "R8 pointer unchanged by idle done");
    drive(4'b1010, 2'b10, 1, 4'b0000, "R7 release");
    drive(4'b0011, 2'b10, 0, 4'b0001, "R7 wrap from pointer 2");
    drive(4'b0011, 2'b10, 1, 4'b0000, "R7 release");
    drive(4'b0001, 2'b10, 0, 4'b0001, "R7 skip non-requesters");
    drive(4'b0001, 2'b10, 1, 4'b0000, "R7 release");
    drive(4'b1111, 2'b10, 0, 4'b0010, "R7 pointer one past 0");
    drive(4'b1111, 2'b10, 1, 4'b0000, "R7 release");

    // time-slotted
    for (int k = 0; k < 2 * N * SLOT_CYC; k++) slot_step(4'b0101, 1'b1, "R6 owner-only grants");
    for (int k = 0; k < 2 * SLOT_CYC + 2; k++) slot_step(4'b1111, 1'b0, "R6 grant held across slots");
    slot_step(4'b1111, 1'b1, "R6 release");
    for (int k = 0; k < N * SLOT_CYC; k++) slot_step(4'b0000, 1'b0, "R6 no requests, no grant");
    for (int k = 0; k < N * SLOT_CYC; k++) slot_step(4'b1000, 1'b1, "R6 single requester waits for slot");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule